// File: doc/BRIEF.md
# Radix-4 Booth Sequential Signed Multiplier

This block multiplies a two's complement multiplicand of `A_W` bits by a two's complement multiplier of `B_W` bits, where `B_W` is even. It returns the full `A_W+B_W`-bit signed product. A single adder is shared across iterations. Each clock, the block consumes two multiplier bits, so a product takes `B_W/2` iterations instead of `B_W`.

Every iteration inspects three overlapping multiplier bits: the two new bits and the highest bit consumed in the step before. It turns them into one signed digit from {-2, -1, 0, +1, +2}. That digit times the multiplicand is added into a guarded accumulator. The accumulator then shifts right arithmetically by two places, and the two low bits drop into the register that held the multiplier. Subtraction is performed as the bitwise inverse plus a carry-in of one.

A caller raises `start` for one cycle while the block is idle. `busy` then stays high for the iterations, and `done` pulses once when `product` is valid.

Top module: `booth4_seq_mult`

## Requirements
- R1: While reset is applied, and on the first cycle after it, `busy`, `done` and `product` are all zero.
- R2: A `start` sampled high while `busy` is low captures `a_in` and `b_in`, and `busy` is high in the next cycle.
- R3: `done` is high for exactly one cycle, and it falls in the cycle that follows the `B_W/2 + 1`-th rising edge after the accepted start. With the bench sizes (`B_W`=6) this is the 4th edge. `busy` is low in that cycle.
- R4: When `done` is high, `product` equals the signed product of the captured operands. The operands are read as two's complement, and the product is `A_W+B_W` bits wide.
- R5: Each multiplier bit triplet (upper, middle, lower) selects a digit. The values 000 and 111 give 0. The values 001 and 010 give +A. The value 011 gives +2A. The value 100 gives -2A. The values 101 and 110 give -A. The first triplet is taken at bits 1 and 0, and each later triplet sits two bits higher.
- R6: The bit below multiplier bit 0 is taken as 0. A multiplier of +1 therefore yields the multiplicand itself.
- R7: A `start` raised while `busy` is high is ignored. The operation in flight keeps its operands and its timing, and no new operation begins after it.
- R8: While `busy` is low and `start` is low, `product` does not change.
- R9: The most negative multiplicand times the most negative multiplier gives the positive value 2^(A_W+B_W-2) without wrapping.
- R10: `busy` and `done` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication when idle |
| a_in | input | A_W | Signed multiplicand |
| b_in | input | B_W | Signed multiplier, even width |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle pulse, product valid |
| product | output | A_W+B_W | Signed product |

## Verification
The hard cases are operand pairs that make the guarded accumulator reach its largest magnitude. Long runs of ones in the multiplier turn into a -2A or -A digit followed by carries into higher digits, and the most negative multiplicand stresses the two guard bits. These patterns are not rare inputs that a random bench might miss. With a 6-by-6 configuration, the bench sweeps all 4096 operand pairs, so every triplet sequence and both extremes are covered. A separate sequence raises `start` in the middle of an operation, with different operands on the inputs, to show that the request is dropped.

// File: rtl/booth4_pkg.sv
package booth4_pkg;

   typedef enum logic [1:0] {
      MAG_ZERO = 2'd0,
      MAG_ONE  = 2'd1,
      MAG_TWO  = 2'd2
   } mag_e;

   typedef struct packed {
      mag_e mag;
      logic neg;
   } digit_t;

   // Triplet order: {upper, middle, lower}; lower is the bit consumed last step.
   function automatic digit_t triplet_to_digit(input logic [2:0] trip);
      digit_t d;
      unique case (trip)
         3'b000, 3'b111: d = '{mag: MAG_ZERO, neg: 1'b0};
         3'b001, 3'b010: d = '{mag: MAG_ONE,  neg: 1'b0};
         3'b011:         d = '{mag: MAG_TWO,  neg: 1'b0};
         3'b100:         d = '{mag: MAG_TWO,  neg: 1'b1};
         default:        d = '{mag: MAG_ONE,  neg: 1'b1};
      endcase
      return d;
   endfunction

endpackage

// File: rtl/booth4_recode.sv
module booth4_recode
   import booth4_pkg::*;
(
   input  logic [2:0] trip,
   output digit_t     digit
);

   always_comb digit = triplet_to_digit(trip);

   // R5
   always_comb begin
      recode_zero_chk: assert (!((trip == 3'b000 || trip == 3'b111) && digit.mag != MAG_ZERO));
   end

endmodule

// File: rtl/booth4_pp_gen.sv
module booth4_pp_gen
   import booth4_pkg::*;
#(
   parameter int A_W      = 8,
   parameter bit INV_FORM = 1'b1,
   localparam int PW      = A_W + 2
)(
   input  logic [A_W-1:0] a,
   input  digit_t         digit,
   output logic [PW-1:0]  pp,
   output logic           cin
);

   logic [PW-1:0] mag_val;

   always_comb begin
      unique case (digit.mag)
         MAG_ONE: mag_val = {{2{a[A_W-1]}}, a};
         MAG_TWO: mag_val = {a[A_W-1], a, 1'b0};
         default: mag_val = '0;
      endcase
   end

   generate
      if (INV_FORM) begin : g_inv
         // Negation as inverse plus carry-in, folded into the shared adder.
         assign pp  = digit.neg ? ~mag_val : mag_val;
         assign cin = digit.neg;
      end else begin : g_neg
         assign pp  = digit.neg ? (~mag_val + 1'b1) : mag_val;
         assign cin = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/booth4_ctrl.sv
module booth4_ctrl #(
   parameter int ITER = 4,
   localparam int CW  = $clog2(ITER + 1)
)(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic step,
   output logic busy_o,
   output logic done_o
);

   logic [CW-1:0] cnt;
   logic          last;

   assign load = start && !busy_o;
   assign step = busy_o;
   assign last = (cnt == CW'(ITER - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         done_o <= 1'b0;
         cnt    <= '0;
      end else begin
         done_o <= 1'b0;
         if (load) begin
            busy_o <= 1'b1;
            cnt    <= '0;
         end else if (busy_o) begin
            if (last) begin
               busy_o <= 1'b0;
               done_o <= 1'b1;
            end
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R2
   launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy_o) |=> busy_o);
   // R3
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R3
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (cnt < CW'(ITER)));
   // R7
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !last) |=> busy_o);

endmodule

// File: rtl/booth4_seq_mult.sv
module booth4_seq_mult
   import booth4_pkg::*;
#(
   parameter int A_W      = 8,
   parameter int B_W      = 8,
   parameter bit INV_FORM = 1'b1,
   localparam int PW      = A_W + 2,
   localparam int ITER    = B_W / 2,
   localparam int RW      = A_W + B_W
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [A_W-1:0] a_in,
   input  logic [B_W-1:0] b_in,
   output logic          busy,
   output logic          done,
   output logic [RW-1:0] product
);

   generate
      if ((B_W % 2) != 0 || B_W < 2 || A_W < 2) begin : g_bad_cfg
         $error("booth4_seq_mult: B_W must be even and >= 2, A_W >= 2");
      end
   endgenerate

   logic [A_W-1:0] a_q;
   logic [PW-1:0]  acc_hi;
   logic [B_W-1:0] acc_lo;
   logic           guard_q;
   logic           load, step;
   digit_t         digit;
   logic [PW-1:0]  pp;
   logic           cin;
   logic [PW-1:0]  sum;
   logic [PW-1:0]  hi_next;
   logic [B_W-1:0] lo_next;

   booth4_ctrl #(.ITER(ITER)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .load   (load),
      .step   (step),
      .busy_o (busy),
      .done_o (done)
   );

   booth4_recode u_recode (
      .trip  ({acc_lo[1], acc_lo[0], guard_q}),
      .digit (digit)
   );

   booth4_pp_gen #(.A_W(A_W), .INV_FORM(INV_FORM)) u_pp (
      .a     (a_q),
      .digit (digit),
      .pp    (pp),
      .cin   (cin)
   );

   assign sum     = acc_hi + pp + PW'(cin);
   assign hi_next = {{2{sum[PW-1]}}, sum[PW-1:2]};

   generate
      if (B_W == 2) begin : g_lo_narrow
         assign lo_next = sum[1:0];
      end else begin : g_lo_wide
         assign lo_next = {sum[1:0], acc_lo[B_W-1:2]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q     <= '0;
         acc_hi  <= '0;
         acc_lo  <= '0;
         guard_q <= 1'b0;
      end else if (load) begin
         a_q     <= a_in;
         acc_hi  <= '0;
         acc_lo  <= b_in;
         guard_q <= 1'b0;
      end else if (step) begin
         acc_hi  <= hi_next;
         acc_lo  <= lo_next;
         guard_q <= acc_lo[1];
      end
   end

   assign product = {acc_hi[A_W-1:0], acc_lo};

   // R10
   done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));
   // R3
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));
   // R8
   product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(product));
   // R6
   guard_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !guard_q);

endmodule

// File: tb/booth4_seq_mult_test.sv
module booth4_seq_mult_test;

   localparam int NA = 6;
   localparam int NB = 6;
   localparam int NR = NA + NB;
   localparam int LAT = NB / 2 + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [NA-1:0] a_in = '0;
   logic [NB-1:0] b_in = '0;
   logic          busy, done;
   logic [NR-1:0] product;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   booth4_seq_mult #(.A_W(NA), .B_W(NB)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
      .busy(busy), .done(done), .product(product)
   );

   task automatic check(input string req, input longint act, input longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [NR-1:0] ref_prod(input logic [NA-1:0] a, input logic [NB-1:0] b);
      int sa, sb, p;
      sa = int'(a) - (a[NA-1] ? (1 << NA) : 0);
      sb = int'(b) - (b[NB-1] ? (1 << NB) : 0);
      p  = sa * sb;
      return p[NR-1:0];
   endfunction

   task automatic run_op(input logic [NA-1:0] a, input logic [NB-1:0] b, input string req);
      int n;
      @(negedge clk);
      a_in = a; b_in = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 1;
      while (!done && n < 40) begin
         @(negedge clk);
         n++;
      end
      check({req, " product"}, longint'(product), longint'(ref_prod(a, b)));
      check("R3 latency", n, LAT);
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [NR-1:0] held;
      int n;
      repeat (3) @(negedge clk);
      // R1
      check("R1 busy", busy, 0);
      check("R1 done", done, 0);
      check("R1 product", product, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 busy after release", busy, 0);

      // R2
      @(negedge clk);
      a_in = 6'd5; b_in = 6'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R2 busy after start", busy, 1);
      while (!done) @(negedge clk);
      // R10
      check("R10 busy with done", busy, 0);
      check("R4 small product", product, 15);
      @(negedge clk);
      check("R3 done one cycle", done, 0);

      // R6: multiplier +1 yields multiplicand
      run_op(6'b101011, 6'd1, "R6");
      // R9: most negative squared
      run_op(6'b100000, 6'b100000, "R9");
      check("R9 positive value", product, 1 << (NR - 2));
      // R5: long run of ones, and alternating pattern
      run_op(6'd31, 6'b011110, "R5 run");
      run_op(6'b100001, 6'b010101, "R5 alt");
      run_op(6'd31, 6'b111111, "R5 minus one");

      // R7: start during busy is ignored
      @(negedge clk);
      a_in = 6'd7; b_in = 6'd9; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      a_in = 6'd1; b_in = 6'd2; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 3;
      while (!done && n < 40) begin @(negedge clk); n++; end
      check("R7 latency unchanged", n, LAT);
      check("R7 first operands kept", product, 63);
      @(negedge clk);
      check("R7 no relaunch busy", busy, 0);

      // R8: product holds while idle with inputs changing
      held = product;
      a_in = 6'd22; b_in = 6'd17;
      repeat (5) @(negedge clk);
      check("R8 product held", product, held);

      // R4 R5: exhaustive sweep
      for (int i = 0; i < (1 << NA); i++)
         for (int j = 0; j < (1 << NB); j++)
            run_op(NA'(i), NB'(j), "R4 sweep");

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule